// File: doc/BRIEF.md
# Rotating Five-Character Segment Display Driver

This block holds a five-character word and drives five active-low seven-segment digits in parallel. Each word position has its own 3-bit character register. The register captures the shared character code on the rising edge of its own load strobe. The character set is H, E, L, O and blank.

A shared 3-bit rotation select turns the stored word circularly across the digits. Each increment of the select moves the word one place to the right. Every digit picks one of the five stored characters through its own five-way selector. Each picked code is then decoded to a segment pattern. The registers are the only state. The selection and the decoding are combinational, so a change of the rotation select shows up on the outputs in the same cycle.

Top module: `rot_word_display`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) sets every character register to blank. It also clears the strobe history. From the next cycle all five outputs read 7'b1111111.
- R2: When `load_stb[k]` is high in a cycle and was low in the cycle before, word slot k takes `char_code` at that clock edge. With `rot_sel` = 000, slot k is shown on `seg<k>` from the next cycle. `seg4` is the leftmost digit.
- R3: A strobe that stays high captures only once. Later changes of `char_code` while the strobe is held leave the register, and the digit it drives, unchanged.
- R4: Segment bit i drives segment i (a=0 … g=6), and a lit segment is 0. The codes map as follows: 000 = H = 7'b0001001, 001 = E = 7'b0000110, 010 = L = 7'b1000111, 011 = O = 7'b1000000.
- R5: Codes 100, 101, 110 and 111 display blank (7'b1111111).
- R6: For `rot_sel` = r with r < 5, `seg<k>` shows slot (k + r) mod 5. With HELLO loaded (H in slot 4, O in slot 0), select values 000 to 100 give HELLO, OHELL, LOHEL, LLOHE and ELLOH, read from `seg4` to `seg0`.
- R7: `rot_sel` values 101, 110 and 111 blank all five digits.
- R8: A change of `rot_sel` changes the outputs in the same cycle, with no register stage.
- R9: When a load and a rotation change fall in the same cycle, the new rotation shows at once. The newly loaded character appears from the next cycle.
- R10: Several strobes rising at the same edge all load the same `char_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| char_code | input | 3 | Character code to load |
| load_stb | input | 5 | Per-slot load strobes, rising-edge captured |
| rot_sel | input | 3 | Rotation amount |
| seg0 | output | 7 | Rightmost digit, active-low segments |
| seg1 | output | 7 | Digit 1 segments |
| seg2 | output | 7 | Digit 2 segments |
| seg3 | output | 7 | Digit 3 segments |
| seg4 | output | 7 | Leftmost digit segments |

## Verification
A register load and a rotation change can fall in the same cycle. This happens when a strobe rises in the same cycle that `rot_sel` moves to a new value. The bench provokes it by raising a strobe while it also moves the select. It then judges the outputs in that cycle and in the next. The first cycle must show the new rotation applied to the old word, and the next cycle must show the new character. A behavioural model, compared on every cycle, supplies both expected patterns.

// File: rtl/rwd_pkg.sv
package rwd_pkg;
    localparam int NUM_DIGITS = 5;
    localparam int CODE_W     = 3;
    localparam int SEG_W      = 7;
    localparam logic [CODE_W-1:0] CODE_BLANK = 3'b100;
    localparam logic [SEG_W-1:0]  SEG_OFF    = '1;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;
    typedef code_t [NUM_DIGITS-1:0] word_t;
endpackage

// File: rtl/rwd_char_bank.sv
module rwd_char_bank
    import rwd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  code_t                 code_i,
    input  logic [NUM_DIGITS-1:0] stb_i,
    output word_t                 word_o
);
    typedef struct packed {
        word_t                 slots;
        logic [NUM_DIGITS-1:0] stb_prev;
    } bank_t;

    bank_t st_d, st_q;
    logic [NUM_DIGITS-1:0] rise;

    assign rise = stb_i & ~st_q.stb_prev;

    always_comb begin
        st_d          = st_q;
        st_d.stb_prev = stb_i;
        for (int k = 0; k < NUM_DIGITS; k++) begin
            if (rise[k]) st_d.slots[k] = code_i;
        end
        if (rst) begin
            for (int k = 0; k < NUM_DIGITS; k++) st_d.slots[k] = CODE_BLANK;
            st_d.stb_prev = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign word_o = st_q.slots;
endmodule

// File: rtl/rwd_rot_select.sv
module rwd_rot_select
    import rwd_pkg::*;
(
    input  word_t      word_i,
    input  code_t      rot_i,
    output word_t      pick_o
);
    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
        always_comb begin
            pick_o[k] = CODE_BLANK;
            for (int j = 0; j < NUM_DIGITS; j++) begin
                if (rot_i == CODE_W'(j)) pick_o[k] = word_i[(k + j) % NUM_DIGITS];
            end
        end
    end
endmodule

// File: rtl/rwd_seg_decode.sv
module rwd_seg_decode
    import rwd_pkg::*;
(
    input  code_t code_i,
    output seg_t  seg_o
);
    always_comb begin
        unique case (code_i)
            3'b000:  seg_o = 7'b0001001;
            3'b001:  seg_o = 7'b0000110;
            3'b010:  seg_o = 7'b1000111;
            3'b011:  seg_o = 7'b1000000;
            default: seg_o = SEG_OFF;
        endcase
    end
endmodule

// File: rtl/rot_word_display.sv
module rot_word_display
    import rwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] char_code,
    input  logic [4:0] load_stb,
    input  logic [2:0] rot_sel,
    output logic [6:0] seg0,
    output logic [6:0] seg1,
    output logic [6:0] seg2,
    output logic [6:0] seg3,
    output logic [6:0] seg4
);
    word_t slots;
    word_t picked;
    seg_t  segs [NUM_DIGITS];

    rwd_char_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .code_i (char_code),
        .stb_i  (load_stb),
        .word_o (slots)
    );

    rwd_rot_select u_rot (
        .word_i (slots),
        .rot_i  (rot_sel),
        .pick_o (picked)
    );

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_dec
        rwd_seg_decode u_dec (
            .code_i (picked[k]),
            .seg_o  (segs[k])
        );
    end

    assign seg0 = segs[0];
    assign seg1 = segs[1];
    assign seg2 = segs[2];
    assign seg3 = segs[3];
    assign seg4 = segs[4];
endmodule

// File: rtl/rwd_checker.sv
module rwd_checker
    import rwd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic [2:0] char_code,
    input logic [4:0] load_stb,
    input logic [2:0] rot_sel,
    input word_t      slots,
    input logic [6:0] seg0,
    input logic [6:0] seg1,
    input logic [6:0] seg2,
    input logic [6:0] seg3,
    input logic [6:0] seg4
);
    logic [NUM_DIGITS-1:0] stb_seen;
    logic                  all_off;

    always_ff @(posedge clk) begin
        if (rst) stb_seen <= '0;
        else     stb_seen <= load_stb;
    end

    assign all_off = (seg0 == SEG_OFF) && (seg1 == SEG_OFF) && (seg2 == SEG_OFF)
                  && (seg3 == SEG_OFF) && (seg4 == SEG_OFF);

    AST_RESET_BLANK: assert property (@(posedge clk) rst |=> all_off); // R1

    AST_ROT_HIGH_BLANK: assert property (@(posedge clk) disable iff (rst)
        (rot_sel > 3'd4) |-> all_off); // R7

    AST_HELD_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        ((load_stb & ~stb_seen) == '0) |=> $stable(slots)); // R3

    for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_cap
        AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
            (load_stb[k] && !stb_seen[k]) |=> (slots[k] == $past(char_code))); // R2
    end
endmodule

bind rot_word_display rwd_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .char_code (char_code),
    .load_stb  (load_stb),
    .rot_sel   (rot_sel),
    .slots     (slots),
    .seg0      (seg0),
    .seg1      (seg1),
    .seg2      (seg2),
    .seg3      (seg3),
    .seg4      (seg4)
);

// File: tb/sim_rot_word_display.sv
`timescale 1ns/1ps
module sim_rot_word_display;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] char_code;
    logic [4:0] load_stb;
    logic [2:0] rot_sel;
    logic [6:0] seg0, seg1, seg2, seg3, seg4;

    int errors = 0;
    int checks = 0;
    int m_slot [5];
    bit m_prev [5];

    always #10 clk = ~clk;

    rot_word_display u0 (
        .clk(clk), .rst(rst), .char_code(char_code), .load_stb(load_stb),
        .rot_sel(rot_sel), .seg0(seg0), .seg1(seg1), .seg2(seg2),
        .seg3(seg3), .seg4(seg4)
    );

    function automatic logic [6:0] pattern(int c);
        case (c)
            0: return 7'b0001001;
            1: return 7'b0000110;
            2: return 7'b1000111;
            3: return 7'b1000000;
            default: return 7'b1111111;
        endcase
    endfunction

    always @(posedge clk) begin
        for (int k = 0; k < 5; k++) begin
            if (rst) begin
                m_slot[k] = 4;
                m_prev[k] = 1'b0;
            end else begin
                if (load_stb[k] && !m_prev[k]) m_slot[k] = int'(char_code);
                m_prev[k] = load_stb[k];
            end
        end
    end

    task automatic step(input string tag, input bit r, input int code,
                        input logic [4:0] ld, input int rot);
        logic [6:0] got [5];
        logic [6:0] exp;
        @(negedge clk);
        rst = r; char_code = 3'(code); load_stb = ld; rot_sel = 3'(rot);
        #2;
        got[0] = seg0; got[1] = seg1; got[2] = seg2; got[3] = seg3; got[4] = seg4;
        for (int k = 0; k < 5; k++) begin
            exp = (rot > 4) ? 7'b1111111 : pattern(m_slot[(k + rot) % 5]);
            checks++;
            if (got[k] !== exp) begin
                errors++;
                $display("FAIL %s seg%0d actual=%b expected=%b", tag, k, got[k], exp);
            end
        end
    endtask

    initial begin
        #4000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int k = 0; k < 5; k++) begin m_slot[k] = 4; m_prev[k] = 1'b0; end
        rst = 1'b1; char_code = 3'd0; load_stb = 5'b11111; rot_sel = 3'd0;
        @(negedge clk); @(negedge clk);
        step("R1_reset", 1'b0, 0, 5'b00000, 0);
        step("R1_reset_rot", 1'b0, 0, 5'b00000, 3);
        // load HELLO: slot4=H, slot3=E, slots2+1=L (R10), slot0=O
        step("R2_load_H", 1'b0, 0, 5'b10000, 0);
        step("R2_load_E", 1'b0, 1, 5'b01000, 0);
        step("R10_dual", 1'b0, 2, 5'b00110, 0);
        step("R2_load_O", 1'b0, 3, 5'b00001, 0);
        step("R4_hello", 1'b0, 3, 5'b00000, 0);
        for (int r = 0; r < 5; r++) step("R6_rotate", 1'b0, 0, 5'b00000, r);
        step("R8_same_cycle", 1'b0, 0, 5'b00000, 2);
        step("R8_same_cycle", 1'b0, 0, 5'b00000, 0);
        for (int r = 5; r < 8; r++) step("R7_rot_blank", 1'b0, 0, 5'b00000, r);
        // held strobe: capture E once, then code changes are ignored
        step("R3_hold", 1'b0, 1, 5'b00001, 0);
        step("R3_hold", 1'b0, 2, 5'b00001, 0);
        step("R3_hold", 1'b0, 0, 5'b00001, 0);
        step("R3_hold", 1'b0, 0, 5'b00000, 0);
        for (int c = 4; c < 8; c++) begin
            step("R5_blank_code", 1'b0, c, 5'b00100, 0);
            step("R5_blank_code", 1'b0, c, 5'b00000, 1);
        end
        // load and rotation change in one cycle
        step("R9_joint", 1'b0, 1, 5'b10000, 1);
        step("R9_joint", 1'b0, 1, 5'b00000, 1);
        step("R9_joint", 1'b0, 1, 5'b00000, 4);
        step("R1_reset_again", 1'b1, 0, 5'b00000, 0);
        step("R1_reset_again", 1'b0, 0, 5'b00000, 2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule